// File: doc/BRIEF.md
# PCIe Inbound Address Translation Unit

This block sits between the receive side of a PCI Express port and the internal memory fabric. Every inbound memory request presents an address, a posted/non-posted flag and a valid strobe. The address is compared against a small set of inbound windows. Each window has a base, a power-of-two size and a translated base. When a window hits, the address bits at and above the window size are replaced by the window's translated base. The bits below the size are kept. The request then leaves toward memory one clock later, tagged with the index of the window that claimed it.

Window 0 is special. Its translated base is fixed to the internal configuration register space and its size is fixed at 1 MiB. Only its base is programmable, through the register at offset 0x010, and it is always enabled. The other windows are fully programmable through a simple register port, and each one starts out disabled.

A request that matches no window is handled according to its type. A non-posted request raises a one-cycle Unsupported Request strobe so that the completion logic can answer it. A posted request is dropped with no output at all.

Top module: `pcie_inb_xlat`

## Requirements
- R1: A request sampled with `req_valid` high at a rising clock edge produces its result (`mem_valid` or `ur_valid`, or nothing) during exactly the following clock cycle. Requests on back-to-back cycles produce results on back-to-back cycles, in the same order.
- R2: Window 0 is always enabled and covers 1 MiB. Its base register sits at offset 0x010 and stores only bits [31:20]; bits [19:0] read as zero. A hit on window 0 gives `mem_addr` = {`CFG_BASE`[31:20], request bits [19:0]} with `mem_win` = 0.
- R3: A hit on programmable window n of size 2^s gives `mem_addr` = translated-base bits [31:s] joined with request bits [s-1:0], and `mem_win` = n.
- R4: A non-posted request (`req_posted` = 0) that hits no window pulses `ur_valid` for one cycle, and `mem_valid` stays low.
- R5: A posted request (`req_posted` = 1) that hits no window produces neither `mem_valid` nor `ur_valid`. A posted request that hits a window is forwarded like any other request.
- R6: When several enabled windows match, the lowest-numbered one claims the request, and `mem_win` reports its index.
- R7: Bit 31 of a window's attribute register is its enable. It resets to 0, and a disabled window never hits.
- R8: Bits [5:0] of the attribute register hold log2 of the window size in bytes. Values below 12 act as 12 (4 KiB). Values above 32 act as 32, so the window covers the whole address space.
- R9: Window n (n >= 1) has its translated base at offset 0xE00 - 0x20*n (window 1 at 0xDE0, window 2 at 0xDC0, window 3 at 0xDA0), its base at that offset + 0x8, and its attribute at that offset + 0x10. Base and translated-base registers store only bits [31:12], so bits [11:0] read as zero. Attribute reads return {enable, 25'b0, size}. Unmapped offsets read as zero.
- R10: During and after reset, `mem_valid` and `ur_valid` are low, and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Inbound request present this cycle |
| req_posted | input | 1 | 1 = posted request, 0 = non-posted request |
| req_addr | input | 32 | Inbound request address |
| mem_valid | output | 1 | Translated request forwarded to memory |
| mem_addr | output | 32 | Translated address |
| mem_win | output | $clog2(NWIN) | Index of the window that claimed the request |
| ur_valid | output | 1 | Unsupported Request completion strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |

## Verification
The assertions check the following on every cycle:
- `mem_valid` and `ur_valid` are never high together.
- No result appears without a request in the previous cycle.
- An Unsupported Request strobe only ever follows a non-posted request.
- Every window-0 hit keeps the low 20 address bits and carries the configuration-space base above them.

The bench's scenarios cover the rest:
- Translation values for each programmable window and lowest-index priority between overlapping windows.
- Clamping of out-of-range sizes and the effect of the enable bit.
- Posted misses producing no output, register readback masking, and ordering under back-to-back traffic.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
  localparam int ADDR_W       = 32;  // request and register data width
  localparam int PAGE_LOG2    = 12;  // smallest window: 4 KiB
  localparam int CFG_WIN_LOG2 = 20;  // fixed window 0 size: 1 MiB
  localparam int REG_AW       = 12;  // register offset width
  localparam int SZ_W         = 6;   // size field width

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [SZ_W-1:0]   size_t;
endpackage

// File: rtl/pxl_regs.sv
module pxl_regs
  import pxl_pkg::*;
#(
  parameter int    NWIN     = 4,
  parameter addr_t CFG_BASE = 32'hFE00_0000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_we,
  input  logic [REG_AW-1:0]       reg_addr,
  input  logic [ADDR_W-1:0]       reg_wdata,
  output logic [ADDR_W-1:0]       reg_rdata,
  output logic [NWIN-1:0][ADDR_W-1:0] win_base,
  output logic [NWIN-1:0][ADDR_W-1:0] win_xlat,
  output logic [NWIN-1:0][SZ_W-1:0]   win_size,
  output logic [NWIN-1:0]             win_en
);
  localparam int    BLK_STRIDE = 32;
  localparam int    BLK_TOP    = 'hE00;
  localparam addr_t PAGE_MASK  = ~addr_t'((1 << PAGE_LOG2) - 1);
  localparam addr_t CFG_MASK   = ~addr_t'((1 << CFG_WIN_LOG2) - 1);
  localparam logic [REG_AW-1:0] W0_OFF = 12'h010;

  logic [NWIN-1:0][ADDR_W-1:0] rd_part;

  // window 0: only its base is writable
  addr_t w0_base_q, w0_base_d;

  always_comb begin
    w0_base_d = w0_base_q;
    if (reg_we && reg_addr == W0_OFF) w0_base_d = reg_wdata & CFG_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) w0_base_q <= '0;
    else        w0_base_q <= w0_base_d;
  end

  assign win_base[0] = w0_base_q;
  assign win_xlat[0] = CFG_BASE & CFG_MASK;
  assign win_size[0] = SZ_W'(CFG_WIN_LOG2);
  assign win_en[0]   = 1'b1;
  assign rd_part[0]  = (reg_addr == W0_OFF) ? w0_base_q : '0;

  for (genvar n = 1; n < NWIN; n++) begin : g_win
    localparam logic [REG_AW-1:0] OFF_X = REG_AW'(BLK_TOP - BLK_STRIDE * n);
    localparam logic [REG_AW-1:0] OFF_B = OFF_X + REG_AW'(8);
    localparam logic [REG_AW-1:0] OFF_A = OFF_X + REG_AW'(16);

    addr_t xlat_q, xlat_d, base_q, base_d;
    size_t size_q, size_d;
    logic  en_q, en_d;

    always_comb begin
      xlat_d = xlat_q;
      base_d = base_q;
      size_d = size_q;
      en_d   = en_q;
      if (reg_we) begin
        if (reg_addr == OFF_X) xlat_d = reg_wdata & PAGE_MASK;
        if (reg_addr == OFF_B) base_d = reg_wdata & PAGE_MASK;
        if (reg_addr == OFF_A) begin
          en_d   = reg_wdata[ADDR_W-1];
          size_d = reg_wdata[SZ_W-1:0];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        xlat_q <= '0;
        base_q <= '0;
        size_q <= '0;
        en_q   <= 1'b0;
      end else begin
        xlat_q <= xlat_d;
        base_q <= base_d;
        size_q <= size_d;
        en_q   <= en_d;
      end
    end

    assign win_base[n] = base_q;
    assign win_xlat[n] = xlat_q;
    assign win_size[n] = size_q;
    assign win_en[n]   = en_q;

    always_comb begin
      rd_part[n] = '0;
      if (reg_addr == OFF_X) rd_part[n] = xlat_q;
      if (reg_addr == OFF_B) rd_part[n] = base_q;
      if (reg_addr == OFF_A) rd_part[n] = {en_q, {(ADDR_W-1-SZ_W){1'b0}}, size_q};
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NWIN; i++) reg_rdata = reg_rdata | rd_part[i];
  end
endmodule

// File: rtl/pxl_match.sv
module pxl_match
  import pxl_pkg::*;
(
  input  addr_t      req_addr,
  input  addr_t      base,
  input  addr_t      xlat,
  input  size_t      size,
  input  logic       en,
  output logic       hit,
  output addr_t      xaddr
);
  int    size_eff;
  addr_t keep_hi;  // 1 for bits at or above the window size

  always_comb begin
    if (int'(size) < PAGE_LOG2)   size_eff = PAGE_LOG2;
    else if (int'(size) > ADDR_W) size_eff = ADDR_W;
    else                          size_eff = int'(size);
  end

  always_comb begin
    for (int i = 0; i < ADDR_W; i++) keep_hi[i] = (i >= size_eff);
  end

  assign hit   = en && ((req_addr & keep_hi) == (base & keep_hi));
  assign xaddr = (xlat & keep_hi) | (req_addr & ~keep_hi);
endmodule

// File: rtl/pxl_pick.sv
module pxl_pick
  import pxl_pkg::*;
#(
  parameter int    NWIN     = 4,
  parameter addr_t CFG_BASE = 32'hFE00_0000,
  localparam int   WIN_W    = $clog2(NWIN)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_posted,
  input  addr_t                       req_addr,
  input  logic [NWIN-1:0]             hit,
  input  logic [NWIN-1:0][ADDR_W-1:0] xaddr,
  output logic                        mem_valid,
  output addr_t                       mem_addr,
  output logic [WIN_W-1:0]            mem_win,
  output logic                        ur_valid
);
  logic [WIN_W-1:0] sel;
  logic             any_hit;
  logic             mem_valid_d, ur_valid_d;
  addr_t            mem_addr_d;

  // lowest index wins: scan from the top so the last assignment is lowest
  always_comb begin
    sel = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit[i]) sel = WIN_W'(i);
    end
  end

  assign any_hit     = |hit;
  assign mem_valid_d = req_valid && any_hit;
  assign ur_valid_d  = req_valid && !any_hit && !req_posted;
  assign mem_addr_d  = xaddr[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      ur_valid  <= 1'b0;
    end else begin
      mem_valid <= mem_valid_d;
      ur_valid  <= ur_valid_d;
    end
  end

  // data path held while idle: clock enable on request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_win  <= '0;
    end else if (req_valid) begin
      mem_addr <= mem_addr_d;
      mem_win  <= sel;
    end
  end

  a_r4_exclusive_result: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_valid && ur_valid));

  a_r1_result_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid || ur_valid) |-> $past(req_valid));

  a_r5_ur_only_nonposted: assert property (@(posedge clk) disable iff (!rst_n)
    ur_valid |-> !$past(req_posted));

  a_r2_cfg_window_xlat: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_win == '0) |->
      (mem_addr[CFG_WIN_LOG2-1:0] == $past(req_addr[CFG_WIN_LOG2-1:0]) &&
       mem_addr[ADDR_W-1:CFG_WIN_LOG2] == CFG_BASE[ADDR_W-1:CFG_WIN_LOG2]));
endmodule

// File: rtl/pcie_inb_xlat.sv
module pcie_inb_xlat
  import pxl_pkg::*;
#(
  parameter int    NWIN     = 4,
  parameter addr_t CFG_BASE = 32'hFE00_0000,
  localparam int   WIN_W    = $clog2(NWIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_posted,
  input  logic [31:0]       req_addr,
  output logic              mem_valid,
  output logic [31:0]       mem_addr,
  output logic [WIN_W-1:0]  mem_win,
  output logic              ur_valid,
  input  logic              reg_we,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  logic rst_meta_q, rst_sync_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [NWIN-1:0][ADDR_W-1:0] win_base, win_xlat, xaddr;
  logic [NWIN-1:0][SZ_W-1:0]   win_size;
  logic [NWIN-1:0]             win_en, hit;

  pxl_regs #(.NWIN(NWIN), .CFG_BASE(CFG_BASE)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .win_base (win_base),
    .win_xlat (win_xlat),
    .win_size (win_size),
    .win_en   (win_en)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_match
    pxl_match u_match (
      .req_addr(req_addr),
      .base    (win_base[w]),
      .xlat    (win_xlat[w]),
      .size    (win_size[w]),
      .en      (win_en[w]),
      .hit     (hit[w]),
      .xaddr   (xaddr[w])
    );
  end

  pxl_pick #(.NWIN(NWIN), .CFG_BASE(CFG_BASE)) u_pick (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .req_valid (req_valid),
    .req_posted(req_posted),
    .req_addr  (req_addr),
    .hit       (hit),
    .xaddr     (xaddr),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .mem_win   (mem_win),
    .ur_valid  (ur_valid)
  );
endmodule

// File: tb/tb_pcie_inb_xlat.sv
module tb_pcie_inb_xlat;
  localparam int CLK_P = 10;
  localparam int K_NONE = 0, K_MEM = 1, K_UR = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_posted;
  logic [31:0] req_addr;
  logic mem_valid, ur_valid;
  logic [31:0] mem_addr;
  logic [1:0]  mem_win;
  logic reg_we;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;
    logic [31:0] addr;
    logic [1:0]  win;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_P/2) clk = ~clk;

  pcie_inb_xlat dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_posted(req_posted), .req_addr(req_addr),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_win(mem_win), .ur_valid(ur_valid),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic send(input logic [31:0] a, input logic p, input int k,
                      input logic [31:0] ea, input logic [1:0] ew, input string tag);
    @(negedge clk);
    req_valid  = 1'b1;
    req_posted = p;
    req_addr   = a;
    sb.push_back('{k, ea, ew, tag});
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== e) begin
      errors++;
      $display("FAIL %s: rdata actual %h expected %h", tag, reg_rdata, e);
    end
  endtask

  // monitor: pops the expected item for every request the design sampled
  always @(posedge clk) begin
    logic pend;
    exp_t e;
    pend = req_valid;
    #1;
    if (pend) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R1: result with empty scoreboard actual mem=%b ur=%b expected none",
                 mem_valid, ur_valid);
      end else begin
        e = sb.pop_front();
        if (e.kind == K_MEM) begin
          if (!(mem_valid === 1'b1 && ur_valid === 1'b0 && mem_addr === e.addr && mem_win === e.win)) begin
            errors++;
            $display("FAIL %s: actual mem=%b ur=%b addr=%h win=%0d expected mem=1 ur=0 addr=%h win=%0d",
                     e.tag, mem_valid, ur_valid, mem_addr, mem_win, e.addr, e.win);
          end
        end else if (e.kind == K_UR) begin
          if (!(ur_valid === 1'b1 && mem_valid === 1'b0)) begin
            errors++;
            $display("FAIL %s: actual mem=%b ur=%b expected mem=0 ur=1", e.tag, mem_valid, ur_valid);
          end
        end else begin
          if (!(ur_valid === 1'b0 && mem_valid === 1'b0)) begin
            errors++;
            $display("FAIL %s: actual mem=%b ur=%b expected mem=0 ur=0", e.tag, mem_valid, ur_valid);
          end
        end
      end
    end else if (rst_n && (mem_valid !== 1'b0 || ur_valid !== 1'b0)) begin
      errors++;
      $display("FAIL R1: spurious output actual mem=%b ur=%b expected 0 0", mem_valid, ur_valid);
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_posted = 1'b0; req_addr = '0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (mem_valid !== 1'b0 || ur_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10: outputs in reset actual %b %b expected 0 0", mem_valid, ur_valid);
    end
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    rd_chk(12'h010, 32'h0, "R10 w0 base after reset");
    rd_chk(12'hDF0, 32'h0, "R10 win1 attr after reset");

    // window 0 at base 0, other windows disabled
    send(32'h0001_2345, 1'b0, K_MEM, 32'hFE01_2345, 2'd0, "R2 w0 nonposted");
    send(32'h000F_FFFF, 1'b1, K_MEM, 32'hFE0F_FFFF, 2'd0, "R5 w0 posted hit");
    send(32'h0010_0000, 1'b0, K_UR,  32'h0, 2'd0, "R4 nonposted miss");
    send(32'h0010_0000, 1'b1, K_NONE, 32'h0, 2'd0, "R5 posted miss dropped");
    idle();

    // window 1: 64 KiB, programmed while disabled
    wr(12'hDE0, 32'h8000_0123);
    wr(12'hDE8, 32'h4000_0FFF);
    wr(12'hDF0, 32'h0000_0010);
    send(32'h4000_1234, 1'b0, K_UR, 32'h0, 2'd0, "R7 disabled window misses");
    idle();
    rd_chk(12'hDE8, 32'h4000_0000, "R9 base low bits masked");
    rd_chk(12'hDE0, 32'h8000_0000, "R9 xlat low bits masked");
    rd_chk(12'h200, 32'h0, "R9 unmapped offset");
    wr(12'hDF0, 32'h8000_0010);
    rd_chk(12'hDF0, 32'h8000_0010, "R9 attr readback");
    send(32'h4000_ABCD, 1'b0, K_MEM, 32'h8000_ABCD, 2'd1, "R3 win1 translate");
    send(32'h4001_0000, 1'b0, K_UR,  32'h0, 2'd0, "R3 win1 above size");
    idle();

    // window 2: 1 MiB overlapping window 1
    wr(12'hDC0, 32'h9000_0000);
    wr(12'hDC8, 32'h4000_0000);
    wr(12'hDD0, 32'h8000_0014);
    send(32'h4000_0010, 1'b0, K_MEM, 32'h8000_0010, 2'd1, "R6 win1 over win2");
    send(32'h4008_0010, 1'b1, K_MEM, 32'h9008_0010, 2'd2, "R3 win2 translate");
    idle();

    // move window 0 on top of the others
    wr(12'h010, 32'h4001_2345);
    rd_chk(12'h010, 32'h4000_0000, "R2 w0 base stores bits 31:20");
    send(32'h4000_0010, 1'b0, K_MEM, 32'hFE00_0010, 2'd0, "R6 win0 over all");
    idle();

    // window 3: size clamping
    wr(12'hDA0, 32'h3000_0000);
    wr(12'hDA8, 32'h2000_0000);
    wr(12'hDB0, 32'h8000_0003);
    send(32'h2000_0FFF, 1'b0, K_MEM, 32'h3000_0FFF, 2'd3, "R8 size below 12 acts as 4 KiB");
    send(32'h2000_1000, 1'b0, K_UR,  32'h0, 2'd0, "R8 4 KiB edge miss");
    idle();
    wr(12'hDB0, 32'h8000_0028);
    send(32'h1234_5678, 1'b0, K_MEM, 32'h1234_5678, 2'd3, "R8 size above 32 covers all");
    send(32'h0000_0004, 1'b1, K_MEM, 32'h0000_0004, 2'd3, "R8 whole space posted");
    send(32'h4000_0020, 1'b0, K_MEM, 32'hFE00_0020, 2'd0, "R1 back-to-back ordering");
    idle();

    repeat (4) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R1: pending results actual %0d expected 0", sb.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule